// File: doc/BRIEF.md
# Single-Destination Interrupt Routing Bank

This block keeps, for every shared peripheral interrupt, the one CPU (out of up to eight) that the interrupt is delivered to. Software reads and writes the bank one 32-bit word at a time. Each word carries four interrupts, one byte per interrupt, and every access comes with the ID of the CPU that issues it. A written byte may have several bits set. The block reduces it to a single destination and stores that. A read returns the stored destination as a one-hot byte.

Next to the register view, the block drives a flat per-CPU bitmap, one bit per shared interrupt, that routing logic downstream consumes directly. The first 32 interrupt numbers are private to each CPU. Their words are a read-only view that reflects the requester. A write that lands in the shared range raises a one-cycle update strobe, so that global interrupt state can be recomputed.

Top module: `rtgt_top`

## Requirements
- R1: Word index `w` covers interrupt numbers `4w` to `4w+3`. Interrupt `4w+l` sits in bits `8l+7:8l`. Words 0 to 7 are private. Word `w >= 8` holds shared interrupt index `s = 4(w-8)+l`.
- R2: On a write in the shared range, each byte is masked to its low `NUM_CPUS` bits. The destination is the index of the lowest set bit that remains.
- R3: A written byte that is zero after masking selects CPU0.
- R4: A read of a shared word returns, in each byte, a one-hot value with only the bit of the stored destination set.
- R5: Writes to words 0 to 7 change nothing. Reads of those words return `1 << req_cpu` repeated in all four bytes.
- R6: After every clock edge, bit `c*NUM_SPI + s` of `cpu_map` is 1 exactly when CPU `c` is the destination of shared interrupt `s`. Each interrupt has exactly one destination, and a write shows in `cpu_map` from the edge that accepts it.
- R7: Reset routes every shared interrupt to CPU0.
- R8: `upd_strobe` is high for exactly the one cycle that follows an accepted write in the shared range. It stays low after reads, private writes and out-of-range writes.
- R9: Words at index `8 + NUM_SPI/4` and above read as zero and ignore writes.
- R10: The read result is registered. `rd_valid` and `rd_data` show the result in the cycle after the request. Otherwise `rd_valid` is 0 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_word | input | ADDR_W | Word index |
| acc_cpu | input | $clog2(NUM_CPUS) | ID of the requesting CPU |
| acc_wdata | input | 32 | Write data, one byte per interrupt |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data holds a read result |
| upd_strobe | output | 1 | One-cycle pulse after a shared-range write |
| cpu_map | output | NUM_CPUS*NUM_SPI | Per-CPU destination bitmap, CPU-major |

## Verification
The bench writes bytes with several bits set, with only the top bit set, and with zero. A design that picked the highest bit, or left a zero byte with no destination, would read back the wrong one-hot byte and leave a `cpu_map` column with zero or two bits set. Private words are read under different requester IDs, and written between reads. A design that stored those writes, or ignored the requester, would return a constant. The bench also touches the last shared word and the first word past it. An off-by-one in the range decode would then either lose the last four interrupts or alias the out-of-range word onto stored state, and could raise a spurious strobe.

// File: rtl/rtgt_pkg.sv
package rtgt_pkg;
  localparam int LANES      = 4;
  localparam int BYTE_W     = 8;
  localparam int PRIV_WORDS = 8;

  typedef enum logic [1:0] {RK_NONE, RK_PRIV, RK_SPI} rkind_e;

  // isolate lowest set bit; an empty byte falls back to CPU0
  function automatic logic [BYTE_W-1:0] pick_lowest(input logic [BYTE_W-1:0] b);
    if (b == '0) return 8'h01;
    return b & (~b + 8'h01);
  endfunction
endpackage

// File: rtl/rtgt_lane_reduce.sv
module rtgt_lane_reduce
  import rtgt_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic [LANES*BYTE_W-1:0]            wdata,
  output logic [LANES-1:0][NUM_CPUS-1:0]     sel
);
  localparam logic [BYTE_W-1:0] CPU_MASK =
    (NUM_CPUS >= BYTE_W) ? 8'hFF : BYTE_W'((1 << NUM_CPUS) - 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] masked, oh;
    always_comb begin
      masked = wdata[l*BYTE_W +: BYTE_W] & CPU_MASK;
      oh     = pick_lowest(masked);
      sel[l] = oh[NUM_CPUS-1:0];
    end
  end
endmodule

// File: rtl/rtgt_map_bank.sv
module rtgt_map_bank
  import rtgt_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SPI  = 64,
  localparam int SPI_WORDS  = NUM_SPI / LANES,
  localparam int SPI_WORD_W = (SPI_WORDS > 1) ? $clog2(SPI_WORDS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [SPI_WORD_W-1:0]             wr_word,
  input  logic [LANES-1:0][NUM_CPUS-1:0]    wr_sel,
  output logic [NUM_SPI-1:0][NUM_CPUS-1:0]  cols,
  output logic [NUM_CPUS*NUM_SPI-1:0]       map_flat
);
  for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
    localparam logic [SPI_WORD_W-1:0] MY_WORD = SPI_WORD_W'(s / LANES);
    localparam int MY_LANE = s % LANES;

    always_ff @(posedge clk) begin
      if (rst)
        cols[s] <= NUM_CPUS'(1);
      else if (wr_en && wr_word == MY_WORD)
        cols[s] <= wr_sel[MY_LANE];
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      assign map_flat[c*NUM_SPI + s] = cols[s][c];
    end

    // R6: every shared interrupt has exactly one destination
    a_r6_one_target: assert property (@(posedge clk) disable iff (rst)
      $countones(cols[s]) == 1);
  end
endmodule

// File: rtl/rtgt_rd_path.sv
module rtgt_rd_path
  import rtgt_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SPI  = 64,
  localparam int SPI_WORDS  = NUM_SPI / LANES,
  localparam int SPI_WORD_W = (SPI_WORDS > 1) ? $clog2(SPI_WORDS) : 1,
  localparam int SPI_W      = SPI_WORD_W + 2,
  localparam int CPU_W      = $clog2(NUM_CPUS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  rkind_e                            rd_kind,
  input  logic [SPI_WORD_W-1:0]             rd_word,
  input  logic [CPU_W-1:0]                  req_cpu,
  input  logic [NUM_SPI-1:0][NUM_CPUS-1:0]  cols,
  output logic [LANES*BYTE_W-1:0]           rd_data,
  output logic                              rd_valid
);
  logic [LANES*BYTE_W-1:0] word_val;
  logic [BYTE_W-1:0]       self_oh;

  assign self_oh = BYTE_W'(1) << req_cpu;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SPI_W-1:0] idx;
    assign idx = {rd_word, 2'(l)};
    always_comb begin
      unique case (rd_kind)
        RK_PRIV: word_val[l*BYTE_W +: BYTE_W] = self_oh;
        RK_SPI:  word_val[l*BYTE_W +: BYTE_W] = BYTE_W'(cols[idx]);
        default: word_val[l*BYTE_W +: BYTE_W] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? word_val : '0;
    end
  end

  // R10: result appears exactly one cycle after the request
  a_r10_rd_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r10_rd_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && rd_data == '0));
endmodule

// File: rtl/rtgt_top.sv
module rtgt_top
  import rtgt_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SPI  = 64,
  parameter int ADDR_W   = 6,
  localparam int SPI_WORDS  = NUM_SPI / LANES,
  localparam int SPI_WORD_W = (SPI_WORDS > 1) ? $clog2(SPI_WORDS) : 1,
  localparam int CPU_W      = $clog2(NUM_CPUS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc_en,
  input  logic                         acc_we,
  input  logic [ADDR_W-1:0]            acc_word,
  input  logic [CPU_W-1:0]             acc_cpu,
  input  logic [31:0]                  acc_wdata,
  output logic [31:0]                  rd_data,
  output logic                         rd_valid,
  output logic                         upd_strobe,
  output logic [NUM_CPUS*NUM_SPI-1:0]  cpu_map
);
  localparam logic [ADDR_W-1:0] PRIV_END = ADDR_W'(PRIV_WORDS);
  localparam logic [ADDR_W-1:0] SPI_END  = ADDR_W'(PRIV_WORDS + SPI_WORDS);

  logic                             in_priv, in_spi, spi_wr, rd_req;
  logic [SPI_WORD_W-1:0]            spi_word;
  logic [LANES-1:0][NUM_CPUS-1:0]   lane_sel;
  logic [NUM_SPI-1:0][NUM_CPUS-1:0] cols;
  rkind_e                           kind;

  always_comb begin
    in_priv  = acc_word < PRIV_END;
    in_spi   = !in_priv && (acc_word < SPI_END);
    spi_word = SPI_WORD_W'(acc_word - PRIV_END);
    spi_wr   = acc_en && acc_we && in_spi;
    rd_req   = acc_en && !acc_we;
    kind     = in_priv ? RK_PRIV : (in_spi ? RK_SPI : RK_NONE);
  end

  rtgt_lane_reduce #(.NUM_CPUS(NUM_CPUS)) u_reduce (
    .wdata (acc_wdata),
    .sel   (lane_sel)
  );

  rtgt_map_bank #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (spi_wr),
    .wr_word  (spi_word),
    .wr_sel   (lane_sel),
    .cols     (cols),
    .map_flat (cpu_map)
  );

  rtgt_rd_path #(.NUM_CPUS(NUM_CPUS), .NUM_SPI(NUM_SPI)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_req),
    .rd_kind  (kind),
    .rd_word  (spi_word),
    .req_cpu  (acc_cpu),
    .cols     (cols),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) upd_strobe <= 1'b0;
    else     upd_strobe <= spi_wr;
  end

  // R8: strobe follows shared-range writes only
  a_r8_strobe_on_write: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_word >= PRIV_END && acc_word < SPI_END) |=> upd_strobe);
  a_r8_no_strobe_else: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && acc_we && acc_word >= PRIV_END && acc_word < SPI_END) |=> !upd_strobe);
  // R5: private writes leave routing untouched
  a_r5_priv_wi: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_word < PRIV_END) |=> $stable(cpu_map));
  // R9: out-of-range accesses touch nothing and read zero
  a_r9_oob_wi: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_we && acc_word >= SPI_END) |=> $stable(cpu_map));
  a_r9_oob_raz: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_we && acc_word >= SPI_END) |=> rd_data == '0);
endmodule

// File: tb/rtgt_top_tb_top.sv
module rtgt_top_tb_top;
  localparam int NCPU = 8;
  localparam int NSPI = 64;
  localparam int AW   = 6;
  localparam int SPI_END = 8 + NSPI/4;

  logic            clk = 1'b0;
  logic            rst;
  logic            acc_en, acc_we;
  logic [AW-1:0]   acc_word;
  logic [2:0]      acc_cpu;
  logic [31:0]     acc_wdata;
  logic [31:0]     rd_data;
  logic            rd_valid, upd_strobe;
  logic [NCPU*NSPI-1:0] cpu_map;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtgt_top #(.NUM_CPUS(NCPU), .NUM_SPI(NSPI), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_word(acc_word), .acc_cpu(acc_cpu), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .upd_strobe(upd_strobe),
    .cpu_map(cpu_map)
  );

  // ---------------- behavioural reference ----------------
  int          tgt [NSPI];
  logic [31:0] m_rd;
  bit          m_valid, m_strobe, m_live = 0;

  function automatic int lowest_cpu(input logic [7:0] b);
    for (int k = 0; k < NCPU; k++) if (b[k]) return k;
    return 0;
  endfunction

  function automatic logic [31:0] model_word(input int w, input int cpu);
    logic [31:0] v = 0;
    if (w < 8) v = {4{8'(1 << cpu)}};
    else if (w < SPI_END)
      for (int l = 0; l < 4; l++) v[8*l +: 8] = 8'(1 << tgt[(w-8)*4 + l]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSPI; s++) tgt[s] = 0;
      m_rd = 0; m_valid = 0; m_strobe = 0; m_live = 1;
    end else if (m_live) begin
      m_valid  = acc_en && !acc_we;
      m_rd     = m_valid ? model_word(int'(acc_word), int'(acc_cpu)) : 32'h0;
      m_strobe = acc_en && acc_we && acc_word >= 8 && acc_word < SPI_END;
      if (m_strobe)
        for (int l = 0; l < 4; l++)
          tgt[(int'(acc_word)-8)*4 + l] = lowest_cpu(acc_wdata[8*l +: 8]);
    end
  end

  function automatic logic [NCPU*NSPI-1:0] model_map();
    logic [NCPU*NSPI-1:0] m = '0;
    for (int s = 0; s < NSPI; s++) m[tgt[s]*NSPI + s] = 1'b1;
    return m;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_live && !done) begin
      checks += 4;
      if (cpu_map !== model_map()) begin
        failures++; $display("FAIL R6 cpu_map act=%h exp=%h", cpu_map, model_map());
      end
      if (rd_valid !== m_valid) begin
        failures++; $display("FAIL R10 rd_valid act=%b exp=%b", rd_valid, m_valid);
      end
      if (rd_data !== m_rd) begin
        failures++; $display("FAIL R4 rd_data act=%h exp=%h", rd_data, m_rd);
      end
      if (upd_strobe !== m_strobe) begin
        failures++; $display("FAIL R8 upd_strobe act=%b exp=%b", upd_strobe, m_strobe);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    @(negedge clk); acc_en = 0; acc_we = 0;
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_word = AW'(w); acc_wdata = d; acc_cpu = 0;
  endtask

  task automatic rd_chk(input int w, input int cpu, input logic [31:0] exp, input string tag);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_word = AW'(w); acc_cpu = 3'(cpu);
    @(negedge clk);
    acc_en = 0;
    checks++;
    if (rd_data !== exp || rd_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s word=%0d act=%h exp=%h", tag, w, rd_data, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    rst = 1; acc_en = 0; acc_we = 0; acc_word = 0; acc_cpu = 0; acc_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R7: reset state routes everything to CPU0
    checks++;
    if (cpu_map !== {{(NCPU-1)*NSPI{1'b0}}, {NSPI{1'b1}}}) begin
      failures++; $display("FAIL R7 cpu_map act=%h exp=cpu0 only", cpu_map);
    end
    rd_chk(8, 0, 32'h01010101, "R7");

    // R2 R3 R4: multi-bit, zero and high-bit bytes
    wr(8, 32'h8006_00FF);
    rd_chk(8, 1, 32'h8002_0101, "R2/R3");
    // R1: lane order within a word
    wr(9, 32'h1020_4080);
    rd_chk(9, 4, 32'h1020_4080, "R1");
    checks++;
    if (cpu_map[7*NSPI + 4] !== 1'b1 || cpu_map[4*NSPI + 7] !== 1'b1) begin
      failures++; $display("FAIL R1 lane map act=%b%b exp=11", cpu_map[7*NSPI+4], cpu_map[4*NSPI+7]);
    end

    // R5: private words are read-only and reflect requester
    rd_chk(3, 5, 32'h2020_2020, "R5");
    wr(3, 32'hFFFF_FFFF);
    rd_chk(3, 2, 32'h0404_0404, "R5");
    rd_chk(0, 7, 32'h8080_8080, "R5");

    // last shared word and first word beyond (R9)
    wr(SPI_END-1, 32'h0102_0408);
    rd_chk(SPI_END-1, 0, 32'h0102_0408, "R4");
    wr(SPI_END, 32'h8080_8080);
    rd_chk(SPI_END, 0, 32'h0, "R9");
    rd_chk(63, 3, 32'h0, "R9");
    rd_chk(8, 0, 32'h8002_0101, "R9");

    // back-to-back writes then idle (R8)
    wr(10, 32'h0000_0003);
    wr(11, 32'h0300_0000);
    idle(); idle();

    // mixed traffic compared every cycle by the reference
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      acc_en    = ($urandom_range(0, 3) != 0);
      acc_we    = $urandom_range(0, 1);
      acc_word  = AW'($urandom_range(0, 30));
      acc_cpu   = 3'($urandom_range(0, 7));
      acc_wdata = ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom;
    end
    idle();

    // R7: mid-run reset restores CPU0 routing
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd_chk(SPI_END-1, 0, 32'h0101_0101, "R7");
    idle(); idle();
    finish_run();
  end
endmodule